// File: doc/BRIEF.md
# Dual-mode serial shift counter port

This block holds a 4-bit data register that serves one of two jobs, picked by a mode bit. In shift mode it is a serial-in/serial-out shifter for a MICROWIRE-style link: on every instruction-cycle strobe it moves its contents one place toward the most significant end and takes the serial input into bit 0. Its top bit can be shown on the serial data output, and the serial clock output is a gated copy of the instruction-cycle clock. In counter mode the same register counts down once for each qualified falling pulse on the serial input. The serial data output then shows a static level, and the serial clock output shows the clock latch.

A host processor runs the port through an exchange operation. The exchange swaps the register with the accumulator and copies the carry bit into the clock latch in the same step. The exchange data path is a stream that is always accepted. It has no valid/ready back-pressure: a request counts only in a cycle where the strobe is high, and it is never stalled. In shift mode, one exchange every four strobes keeps a gap-free serial stream going. The two mode bits come from a control register and are written through a plain write port.

Top module: `serial_nibble_port`

## Requirements
- R1: With the count-mode bit clear (enable bit 0 = 0), each strobe without an exchange sets the register to {register[2:0], si}.
- R2: In shift mode, so equals register bit 3 when the serial-out enable (enable bit 3) is 1, and so is 0 when that bit is 0. Shifting goes on in both cases.
- R3: In shift mode, sk equals the clock latch ANDed with the cyc_clk_lvl input.
- R4: With the count-mode bit set, the register decrements by one at the second consecutive strobe that samples si low after a strobe that sampled si high. A low lasting only one strobe has no effect, and one pulse gives at most one decrement.
- R5: In counter mode, so equals the serial-out enable bit and sk equals the clock latch, whatever the value of cyc_clk_lvl.
- R6: A strobe with xchg_req loads xchg_acc_in into the register and xchg_carry_in into the clock latch. xchg_acc_out always shows the register, so before that edge it shows the value the accumulator receives.
- R7: Reset clears the register and both enable bits and sets the clock latch. After reset, so is 0 and sk follows cyc_clk_lvl.
- R8: An exchange takes priority over a shift or a decrement in the same strobe. That strobe neither shifts nor decrements, and the pulse that would have decremented is used up.
- R9: Decrementing from 0 gives 15.
- R10: Without a strobe the register does not change, whatever the values of si and xchg_req.
- R11: In shift mode with the serial-out enable set, an exchange every fourth strobe puts the loaded nibble on so MSB first, one bit per strobe, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | Instruction-cycle strobe; all register activity happens on strobes |
| cyc_clk_lvl | input | 1 | Instruction-cycle clock level gated onto sk in shift mode |
| en_wr | input | 1 | Write strobe for the two mode bits |
| en_count | input | 1 | Enable bit 0: 1 selects counter mode, 0 selects shift mode |
| en_so | input | 1 | Enable bit 3: serial-out enable |
| xchg_req | input | 1 | Exchange request, acted on only in a strobe cycle |
| xchg_acc_in | input | 4 | Accumulator value loaded by an exchange |
| xchg_carry_in | input | 1 | Carry bit copied into the clock latch by an exchange |
| xchg_acc_out | output | 4 | Current register contents (accumulator side of the exchange) |
| si | input | 1 | Serial input or pulse input |
| so | output | 1 | Serial data output |
| sk | output | 1 | Serial clock output |

## Verification
A wrong register bit shows up on xchg_acc_out in the strobe after it happens. In shift mode with the serial-out enable set, it also reaches so once it has shifted up to bit 3, at most three strobes later. A stuck clock latch shows on sk in the next cycle where cyc_clk_lvl is high, or at once in counter mode. A fault in the pulse qualifier shows as a missing or extra decrement at the strobe that ends a pulse. The bench checks these ports against a behavioural model on every clock, and runs directed cases for wrap, short pulses and exchange collisions.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2,
    OP_DEC   = 2'd3
  } snp_op_e;
endpackage

// File: rtl/snp_ctrl.sv
module snp_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_wr,
  input  logic en_count,
  input  logic en_so,
  input  logic xchg_take,
  input  logic carry_in,
  output logic count_mode_o,
  output logic so_en_o,
  output logic skl_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_mode_o <= 1'b0;
      so_en_o      <= 1'b0;
    end else if (en_wr) begin
      count_mode_o <= en_count;
      so_en_o      <= en_so;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         skl_o <= 1'b1;
    else if (xchg_take) skl_o <= carry_in;
  end
endmodule

// File: rtl/snp_pulse_qual.sv
module snp_pulse_qual #(
  parameter int LOW_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic si,
  output logic fire_o
);
  localparam int CW = $clog2(LOW_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOW_CYCLES - 1);

  logic          armed_q;
  logic [CW-1:0] low_cnt_q;

  // a pulse is qualified on the strobe that sees its last required low sample
  assign fire_o = stb & ~si & armed_q & (low_cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      low_cnt_q <= '0;
    end else if (stb) begin
      if (si) begin
        armed_q   <= 1'b1;
        low_cnt_q <= '0;
      end else if (armed_q) begin
        if (low_cnt_q == LAST) begin
          armed_q   <= 1'b0;
          low_cnt_q <= '0;
        end else begin
          low_cnt_q <= low_cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/snp_core.sv
module snp_core
  import snp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic         xchg,
  input  logic [W-1:0] acc_in,
  input  logic         si,
  input  logic         count_mode,
  input  logic         dec,
  output logic [W-1:0] data_o
);
  snp_op_e op;

  always_comb begin
    op = OP_HOLD;
    if (stb) begin
      if (xchg)             op = OP_LOAD;
      else if (!count_mode) op = OP_SHIFT;
      else if (dec)         op = OP_DEC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
    end else begin
      case (op)
        OP_LOAD:  data_o <= acc_in;
        OP_SHIFT: data_o <= {data_o[W-2:0], si};
        OP_DEC:   data_o <= data_o - W'(1);
        default:  data_o <= data_o;
      endcase
    end
  end
endmodule

// File: rtl/snp_outmux.sv
module snp_outmux (
  input  logic count_mode,
  input  logic so_en,
  input  logic skl,
  input  logic cyc_lvl,
  input  logic msb,
  output logic so,
  output logic sk
);
  assign so = count_mode ? so_en : (so_en & msb);
  assign sk = count_mode ? skl   : (skl & cyc_lvl);
endmodule

// File: rtl/serial_nibble_port.sv
module serial_nibble_port #(
  parameter int W          = 4,
  parameter int LOW_CYCLES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cyc_stb,
  input  logic         cyc_clk_lvl,
  input  logic         en_wr,
  input  logic         en_count,
  input  logic         en_so,
  input  logic         xchg_req,
  input  logic [W-1:0] xchg_acc_in,
  input  logic         xchg_carry_in,
  output logic [W-1:0] xchg_acc_out,
  input  logic         si,
  output logic         so,
  output logic         sk
);
  logic         count_mode_q;
  logic         so_en_q;
  logic         skl_q;
  logic         dec_fire;
  logic [W-1:0] data_q;

  snp_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_wr        (en_wr),
    .en_count     (en_count),
    .en_so        (en_so),
    .xchg_take    (cyc_stb & xchg_req),
    .carry_in     (xchg_carry_in),
    .count_mode_o (count_mode_q),
    .so_en_o      (so_en_q),
    .skl_o        (skl_q)
  );

  snp_pulse_qual #(.LOW_CYCLES(LOW_CYCLES)) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (cyc_stb),
    .si     (si),
    .fire_o (dec_fire)
  );

  snp_core #(.W(W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (cyc_stb),
    .xchg       (xchg_req),
    .acc_in     (xchg_acc_in),
    .si         (si),
    .count_mode (count_mode_q),
    .dec        (dec_fire),
    .data_o     (data_q)
  );

  snp_outmux u_out (
    .count_mode (count_mode_q),
    .so_en      (so_en_q),
    .skl        (skl_q),
    .cyc_lvl    (cyc_clk_lvl),
    .msb        (data_q[W-1]),
    .so         (so),
    .sk         (sk)
  );

  assign xchg_acc_out = data_q;
endmodule

// File: rtl/snp_checker.sv
module snp_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cyc_stb,
  input logic         cyc_clk_lvl,
  input logic         xchg_req,
  input logic [W-1:0] xchg_acc_in,
  input logic         xchg_carry_in,
  input logic [W-1:0] xchg_acc_out,
  input logic         si,
  input logic         so,
  input logic         sk,
  input logic         count_mode,
  input logic         so_en,
  input logic         skl,
  input logic         dec_fire
);
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && !xchg_req && !count_mode) |=> xchg_acc_out == {$past(xchg_acc_out[W-2:0]), $past(si)}); // R1
  AST_SO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_mode && !so_en) |-> !so); // R2
  AST_SO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_mode && so_en) |-> so == xchg_acc_out[W-1]); // R2
  AST_SK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !count_mode |-> sk == (skl & cyc_clk_lvl)); // R3
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && !xchg_req && count_mode && dec_fire) |=> xchg_acc_out == ($past(xchg_acc_out) - W'(1))); // R9
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && !xchg_req && count_mode && !dec_fire) |=> $stable(xchg_acc_out)); // R4
  AST_FIRE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |-> !si); // R4
  AST_CNT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    count_mode |-> (so == so_en && sk == skl)); // R5
  AST_XCHG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && xchg_req) |=> (xchg_acc_out == $past(xchg_acc_in) && skl == $past(xchg_carry_in))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_stb |=> $stable(xchg_acc_out)); // R10
endmodule

bind serial_nibble_port snp_checker #(.W(W)) u_snp_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cyc_stb       (cyc_stb),
  .cyc_clk_lvl   (cyc_clk_lvl),
  .xchg_req      (xchg_req),
  .xchg_acc_in   (xchg_acc_in),
  .xchg_carry_in (xchg_carry_in),
  .xchg_acc_out  (xchg_acc_out),
  .si            (si),
  .so            (so),
  .sk            (sk),
  .count_mode    (count_mode_q),
  .so_en         (so_en_q),
  .skl           (skl_q),
  .dec_fire      (dec_fire)
);

// File: tb/serial_nibble_port_bench.sv
`timescale 1ns/1ps
module serial_nibble_port_bench;
  localparam int LOWN = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_stb = 1'b0;
  logic       cyc_clk_lvl = 1'b0;
  logic       en_wr = 1'b0;
  logic       en_count = 1'b0;
  logic       en_so = 1'b0;
  logic       xchg_req = 1'b0;
  logic [3:0] xchg_acc_in = 4'd0;
  logic       xchg_carry_in = 1'b0;
  logic [3:0] xchg_acc_out;
  logic       si = 1'b0;
  logic       so;
  logic       sk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_nibble_port u_serial_nibble_port (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .cyc_clk_lvl(cyc_clk_lvl),
    .en_wr(en_wr), .en_count(en_count), .en_so(en_so),
    .xchg_req(xchg_req), .xchg_acc_in(xchg_acc_in), .xchg_carry_in(xchg_carry_in),
    .xchg_acc_out(xchg_acc_out), .si(si), .so(so), .sk(sk)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_reg = 0, m_skl = 1, m_cnt = 0, m_soen = 0;
  bit m_seen_high = 0;
  int m_lows = 0;

  always @(posedge clk) begin
    bit fire;
    if (!rst_n) begin
      m_reg = 0; m_skl = 1; m_cnt = 0; m_soen = 0; m_seen_high = 0; m_lows = 0;
    end else begin
      if (cyc_stb) begin
        fire = 0;
        if (si) begin
          m_seen_high = 1; m_lows = 0;
        end else if (m_seen_high) begin
          m_lows = m_lows + 1;
          if (m_lows >= LOWN) begin fire = 1; m_seen_high = 0; m_lows = 0; end
        end
        if (xchg_req) begin
          m_reg = int'(xchg_acc_in); m_skl = int'(xchg_carry_in);
        end else if (m_cnt == 0) begin
          m_reg = ((m_reg * 2) + int'(si)) % 16;
        end else if (fire) begin
          m_reg = (m_reg + 15) % 16;
        end
      end
      if (en_wr) begin m_cnt = int'(en_count); m_soen = int'(en_so); end
    end
    #2;
    if (rst_n && !done) begin
      if (m_cnt != 0) begin
        chk("R4 register (counter)", int'(xchg_acc_out), m_reg);
        chk("R5 so (counter)", int'(so), m_soen);
        chk("R5 sk (counter)", int'(sk), m_skl);
      end else begin
        chk("R1 register (shift)", int'(xchg_acc_out), m_reg);
        chk("R2 so (shift)", int'(so), (m_soen != 0) ? (m_reg / 8) : 0);
        chk("R3 sk (shift)", int'(sk), m_skl & int'(cyc_clk_lvl));
      end
    end
  end

  task automatic icycle(input bit s, input bit x, input logic [3:0] acc, input bit c);
    @(negedge clk);
    cyc_stb = 1; cyc_clk_lvl = 1; si = s; xchg_req = x; xchg_acc_in = acc; xchg_carry_in = c;
    @(negedge clk);
    cyc_stb = 0; cyc_clk_lvl = 0; xchg_req = 0;
    @(posedge clk); #3;
  endtask

  task automatic set_en(input bit cnt, input bit soe);
    @(negedge clk);
    en_wr = 1; en_count = cnt; en_so = soe;
    @(negedge clk);
    en_wr = 0;
    @(posedge clk); #3;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; cyc_clk_lvl = 1;
    @(posedge clk); #3;
    chk("R7 register after reset", int'(xchg_acc_out), 0);
    chk("R7 so after reset", int'(so), 0);
    chk("R7 sk after reset", int'(sk), 1);

    // R1 / R2: shift with serial out disabled
    icycle(1, 0, 0, 0); icycle(0, 0, 0, 0); icycle(1, 0, 0, 0); icycle(1, 0, 0, 0);
    chk("R1 shifted value", int'(xchg_acc_out), 11);
    chk("R2 so held low", int'(so), 0);

    // R10: no strobe, inputs wiggle
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); si = i[0]; xchg_req = 1; xchg_acc_in = 4'd0;
    end
    @(negedge clk); xchg_req = 0;
    @(posedge clk); #3;
    chk("R10 register held", int'(xchg_acc_out), 11);

    // R11 / R6: continuous stream
    set_en(0, 1);
    chk("R2 so shows msb", int'(so), 1);
    icycle(0, 1, 4'b1001, 0);
    chk("R6 exchange loads", int'(xchg_acc_out), 9);
    chk("R11 stream bit 3", int'(so), 1);
    icycle(1, 0, 0, 0); chk("R11 stream bit 2", int'(so), 0);
    icycle(1, 0, 0, 0); chk("R11 stream bit 1", int'(so), 0);
    icycle(0, 0, 0, 0); chk("R11 stream bit 0", int'(so), 1);
    chk("R6 value before exchange", int'(xchg_acc_out), 14);
    icycle(0, 1, 4'b0110, 1);
    chk("R11 next nibble bit 3", int'(so), 0);
    @(negedge clk); cyc_clk_lvl = 1;
    @(posedge clk); #3; chk("R3 sk with clock high", int'(sk), 1);
    @(negedge clk); cyc_clk_lvl = 0;
    @(posedge clk); #3; chk("R3 sk with clock low", int'(sk), 0);

    // counter mode
    set_en(1, 1);
    chk("R5 so equals enable", int'(so), 1);
    icycle(1, 1, 4'd1, 0);
    @(negedge clk); cyc_clk_lvl = 1;
    @(posedge clk); #3; chk("R5 sk ignores clock", int'(sk), 0);
    icycle(1, 0, 0, 0);
    icycle(0, 0, 0, 0); chk("R4 one low strobe no count", int'(xchg_acc_out), 1);
    icycle(0, 0, 0, 0); chk("R4 qualified pulse", int'(xchg_acc_out), 0);
    icycle(1, 0, 0, 0); icycle(0, 0, 0, 0); icycle(0, 0, 0, 0);
    chk("R9 wrap to 15", int'(xchg_acc_out), 15);
    icycle(1, 0, 0, 0); icycle(0, 0, 0, 0); icycle(1, 0, 0, 0);
    chk("R4 short pulse ignored", int'(xchg_acc_out), 15);
    icycle(0, 0, 0, 0); icycle(0, 1, 4'd6, 0);
    chk("R8 exchange beats decrement", int'(xchg_acc_out), 6);
    icycle(0, 0, 0, 0);
    chk("R4 one count per pulse", int'(xchg_acc_out), 6);
    set_en(0, 0);
    icycle(1, 1, 4'd5, 1);
    chk("R8 exchange beats shift", int'(xchg_acc_out), 5);

    // mixed traffic, checked by the model every clock
    for (int k = 0; k < 400; k++) begin
      if (k % 50 == 0) set_en(1'($urandom), 1'($urandom));
      icycle(1'($urandom), ($urandom % 5) == 0, 4'($urandom), 1'($urandom));
      if ((k % 7) == 3) begin
        @(negedge clk); si = 1'($urandom); cyc_clk_lvl = 1;
        @(posedge clk); #3;
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule